// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block decides, in the same cycle, whether a bus access may proceed. Each access presents a master number, a 32-bit address and a read or write flag. The block compares the address against every programmable region at once. It grants the access when a valid region that covers the address gives that master the requested right. Each region has a start bound, an end bound, a valid bit, and a read right and a write right for every master.

A small word-addressed configuration port programs the region descriptors and a global enable. The same port reads back all stored state. The first denied access is latched in an error-capture register, and later denials leave it unchanged until software clears it. A single output flags that a capture is pending.

Top module: `mpu_top`

## Requirements
- R1: After reset the global enable is 0, every region is invalid with zero bounds and rights, no error is pending, and every access is allowed.
- R2: While the global enable (bit 0 of config word 0x40) is 0, every access is allowed and nothing is captured.
- R3: While enabled, an access is allowed exactly when some region grants it. A region grants a read if its read right for that master is set, and grants a write if its write right for that master is set.
- R4: Region bounds have 32-byte granularity. The low 5 bits of a written bound are ignored. A region with start block S and end block E covers addresses S*32 through E*32+31, both ends inclusive.
- R5: A region whose valid bit (bit 0 of field word 2) is 0 never covers any address.
- R6: Rights are separate for each master. The read right of master m is at bit m of field word 3, and its write right is at bit 16+m. A master number of NUM_MASTERS or above is always denied while enabled.
- R7: Regions may overlap. Their grants are combined by OR, so a right given by any covering region is enough.
- R8: The first denied access with no capture pending is latched one cycle later. Word 0x41 then reads bit 0 = pending, bit 1 = write, bits 15:8 = master. Word 0x42 reads the full address.
- R9: While a capture is pending, further denials do not change the captured details.
- R10: Any write to word 0x41 clears the pending capture. A denial in the same cycle as the clear is captured instead.
- R11: Configuration word r*4+f addresses field f of region r: 0 start, 1 end, 2 valid, 3 rights. Bounds read back with the low 5 bits zero. Writes take effect for accesses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data for cfg_addr_i, combinational |
| acc_valid_i | input | 1 | An access is presented |
| acc_master_i | input | 2 | Master number of the access |
| acc_addr_i | input | 32 | Access address |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_allow_o | output | 1 | Access permitted, same cycle |
| err_pending_o | output | 1 | A denied access is held in the capture register |

## Verification
The allow decision is combinational, so it is due in the same cycle as the access. The bench drives inputs after the falling edge and compares one nanosecond later, against a model that still holds the previous configuration. Configuration writes and capture updates become visible only after the next rising edge. The model therefore applies them after its comparison for that cycle, and the pending flag and read-back words are checked in the cycles that follow. Readback is combinational and is sampled in the same way.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  localparam int GRAN_BITS     = 5;
  localparam int WR_RIGHT_LSB  = 16;
  localparam int ERR_MID_LSB   = 8;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_VALID  = 2'd2,
    FLD_RIGHTS = 2'd3
  } region_field_e;

  typedef enum logic [1:0] {
    GLB_ENABLE   = 2'd0,
    GLB_ERR_STAT = 2'd1,
    GLB_ERR_ADDR = 2'd2,
    GLB_RSVD     = 2'd3
  } glb_field_e;
endpackage

// File: rtl/mpu_region.sv
module mpu_region #(
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 32,
  parameter int MID_W       = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  mpu_pkg::region_field_e    field_i,
  input  logic [31:0]               wdata_i,
  input  logic [ADDR_W-1:0]         acc_addr_i,
  input  logic [MID_W-1:0]          acc_master_i,
  input  logic                      acc_write_i,
  output logic                      hit_o,
  output logic                      grant_o,
  output logic [31:0]               rdata_o
);
  import mpu_pkg::*;
  localparam int BLK_W = ADDR_W - GRAN_BITS;

  logic [BLK_W-1:0]       start_q, end_q;
  logic                   valid_q;
  logic [NUM_MASTERS-1:0] rd_q, wr_q;
  logic [BLK_W-1:0]       blk;
  logic                   right_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
      valid_q <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else if (wr_en_i) begin
      unique case (field_i)
        FLD_START:  start_q <= wdata_i[ADDR_W-1:GRAN_BITS];
        FLD_END:    end_q   <= wdata_i[ADDR_W-1:GRAN_BITS];
        FLD_VALID:  valid_q <= wdata_i[0];
        FLD_RIGHTS: begin
          rd_q <= wdata_i[NUM_MASTERS-1:0];
          wr_q <= wdata_i[WR_RIGHT_LSB +: NUM_MASTERS];
        end
        default: ;
      endcase
    end
  end

  assign blk = acc_addr_i[ADDR_W-1:GRAN_BITS];

  // out-of-range master ids match no entry and get no right
  always_comb begin
    right_ok = 1'b0;
    for (int m = 0; m < NUM_MASTERS; m++)
      if (acc_master_i == MID_W'(m)) right_ok = acc_write_i ? wr_q[m] : rd_q[m];
  end

  assign hit_o   = valid_q && (blk >= start_q) && (blk <= end_q);
  assign grant_o = hit_o && right_ok;

  always_comb begin
    rdata_o = '0;
    unique case (field_i)
      FLD_START:  rdata_o = 32'({start_q, {GRAN_BITS{1'b0}}});
      FLD_END:    rdata_o = 32'({end_q, {GRAN_BITS{1'b0}}});
      FLD_VALID:  rdata_o[0] = valid_q;
      FLD_RIGHTS: begin
        rdata_o[NUM_MASTERS-1:0]             = rd_q;
        rdata_o[WR_RIGHT_LSB +: NUM_MASTERS] = wr_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mpu_err_capture.sv
module mpu_err_capture #(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deny_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MID_W-1:0]  master_i,
  input  logic              write_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [MID_W-1:0]  master_o,
  output logic              write_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      master_o <= '0;
      write_o  <= 1'b0;
    end else if (deny_i && (!valid_o || clear_i)) begin
      // a denial beside a clear is kept, not lost
      valid_o  <= 1'b1;
      addr_o   <= addr_i;
      master_o <= master_i;
      write_o  <= write_i;
    end else if (clear_i) begin
      valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/mpu_top.sv
module mpu_top #(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 32,
  localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int CFG_AW     = RIDX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [MID_W-1:0]  acc_master_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  output logic              acc_allow_o,
  output logic              err_pending_o
);
  import mpu_pkg::*;

  logic                   glb_sel;
  logic [RIDX_W-1:0]      ridx;
  region_field_e          rfld;
  glb_field_e             gfld;
  logic                   en_q;
  logic [NUM_REGIONS-1:0] hit_vec, grant_vec;
  logic [31:0]            reg_rdata [NUM_REGIONS];
  logic                   deny, err_clear, err_valid, err_write;
  logic [ADDR_W-1:0]      err_addr;
  logic [MID_W-1:0]       err_master;

  assign glb_sel = cfg_addr_i[CFG_AW-1];
  assign ridx    = cfg_addr_i[CFG_AW-2:2];
  assign rfld    = region_field_e'(cfg_addr_i[1:0]);
  assign gfld    = glb_field_e'(cfg_addr_i[1:0]);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    mpu_region #(
      .NUM_MASTERS (NUM_MASTERS),
      .ADDR_W      (ADDR_W),
      .MID_W       (MID_W)
    ) u_region (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (cfg_we_i && !glb_sel && (ridx == RIDX_W'(r))),
      .field_i      (rfld),
      .wdata_i      (cfg_wdata_i),
      .acc_addr_i   (acc_addr_i),
      .acc_master_i (acc_master_i),
      .acc_write_i  (acc_write_i),
      .hit_o        (hit_vec[r]),
      .grant_o      (grant_vec[r]),
      .rdata_o      (reg_rdata[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 en_q <= 1'b0;
    else if (cfg_we_i && glb_sel && gfld == GLB_ENABLE) en_q <= cfg_wdata_i[0];
  end

  assign acc_allow_o = !en_q || (|grant_vec);
  assign deny        = acc_valid_i && !acc_allow_o;
  assign err_clear   = cfg_we_i && glb_sel && (gfld == GLB_ERR_STAT);

  mpu_err_capture #(
    .ADDR_W (ADDR_W),
    .MID_W  (MID_W)
  ) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .deny_i   (deny),
    .clear_i  (err_clear),
    .addr_i   (acc_addr_i),
    .master_i (acc_master_i),
    .write_i  (acc_write_i),
    .valid_o  (err_valid),
    .addr_o   (err_addr),
    .master_o (err_master),
    .write_o  (err_write)
  );

  assign err_pending_o = err_valid;

  always_comb begin
    cfg_rdata_o = '0;
    if (glb_sel) begin
      unique case (gfld)
        GLB_ENABLE:   cfg_rdata_o[0] = en_q;
        GLB_ERR_STAT: begin
          cfg_rdata_o[0]                   = err_valid;
          cfg_rdata_o[1]                   = err_write;
          cfg_rdata_o[ERR_MID_LSB +: MID_W] = err_master;
        end
        GLB_ERR_ADDR: cfg_rdata_o = 32'(err_addr);
        default: ;
      endcase
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++)
        if (ridx == RIDX_W'(r)) cfg_rdata_o = reg_rdata[r];
    end
  end
endmodule

// File: rtl/mpu_checker.sv
module mpu_checker #(
  parameter int NUM_REGIONS = 16,
  parameter int NUM_MASTERS = 3,
  parameter int ADDR_W      = 32,
  parameter int MID_W       = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   acc_valid_i,
  input logic [MID_W-1:0]       acc_master_i,
  input logic [ADDR_W-1:0]      acc_addr_i,
  input logic                   acc_allow_o,
  input logic                   en_q,
  input logic [NUM_REGIONS-1:0] hit_vec,
  input logic                   err_valid,
  input logic [ADDR_W-1:0]      err_addr,
  input logic                   err_clear
);
  assert_off_allows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !en_q |-> acc_allow_o);

  assert_allow_needs_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && en_q && acc_allow_o |-> (|hit_vec));

  assert_bad_master_denied_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && en_q && (int'(acc_master_i) >= NUM_MASTERS) |-> !acc_allow_o);

  assert_capture_on_deny_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_valid) |-> $past(acc_valid_i && !acc_allow_o) && (err_addr == $past(acc_addr_i)));

  assert_capture_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid && !err_clear |=> err_valid && $stable(err_addr));

  assert_clear_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clear && !(acc_valid_i && !acc_allow_o) |=> !err_valid);
endmodule

bind mpu_top mpu_checker #(
  .NUM_REGIONS (NUM_REGIONS),
  .NUM_MASTERS (NUM_MASTERS),
  .ADDR_W      (ADDR_W),
  .MID_W       (MID_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_master_i (acc_master_i),
  .acc_addr_i   (acc_addr_i),
  .acc_allow_o  (acc_allow_o),
  .en_q         (en_q),
  .hit_vec      (hit_vec),
  .err_valid    (err_valid),
  .err_addr     (err_addr),
  .err_clear    (err_clear)
);

// File: tb/mpu_top_bench.sv
`timescale 1ns/1ps
module mpu_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic [1:0]  acc_master_i = '0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_write_i = 1'b0;
  logic        acc_allow_o;
  logic        err_pending_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mpu_top u_mpu_top (.*);

  // behavioural model
  logic [26:0] m_st [16];
  logic [26:0] m_en [16];
  bit          m_vld [16];
  logic [31:0] m_rt [16];
  bit          m_gen;
  bit          m_ev, m_ew;
  int          m_em;
  logic [31:0] m_ea;

  function automatic bit m_allow(int m, logic [31:0] a, bit w);
    if (!m_gen) return 1'b1;
    for (int r = 0; r < 16; r++)
      if (m_vld[r] && a[31:5] >= m_st[r] && a[31:5] <= m_en[r] && m < 3 &&
          (w ? m_rt[r][16+m] : m_rt[r][m])) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_rd(logic [6:0] ca);
    int r;
    r = int'(ca[5:2]);
    if (ca[6]) begin
      case (ca[1:0])
        2'd0: return {31'b0, m_gen};
        2'd1: return {16'b0, 8'(m_em), 6'b0, m_ew, m_ev};
        2'd2: return m_ea;
        default: return 32'b0;
      endcase
    end
    case (ca[1:0])
      2'd0: return {m_st[r], 5'b0};
      2'd1: return {m_en[r], 5'b0};
      2'd2: return {31'b0, m_vld[r]};
      default: return m_rt[r];
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive after falling edge, compare, then advance model past rising edge
  task automatic cyc(input bit av, input int m, input logic [31:0] a, input bit w,
                     input bit we, input logic [6:0] ca, input logic [31:0] wd, input string tag);
    bit exp_allow, deny, clr;
    int r;
    acc_valid_i = av; acc_master_i = 2'(m); acc_addr_i = a; acc_write_i = w;
    cfg_we_i = we; cfg_addr_i = ca; cfg_wdata_i = wd;
    #1;
    exp_allow = m_allow(m, a, w);
    if (av) check({tag, " allow"}, {31'b0, acc_allow_o}, {31'b0, exp_allow});
    check({tag, " pending"}, {31'b0, err_pending_o}, {31'b0, m_ev});
    deny = av && !exp_allow;
    clr  = we && ca == 7'h41;
    if (deny && (!m_ev || clr)) begin
      m_ev = 1'b1; m_ea = a; m_em = m; m_ew = w;
    end else if (clr) m_ev = 1'b0;
    if (we) begin
      r = int'(ca[5:2]);
      if (ca[6]) begin
        if (ca[1:0] == 2'd0) m_gen = wd[0];
      end else begin
        case (ca[1:0])
          2'd0: m_st[r] = wd[31:5];
          2'd1: m_en[r] = wd[31:5];
          2'd2: m_vld[r] = wd[0];
          default: m_rt[r] = wd & 32'h0007_0007;
        endcase
      end
    end
    @(negedge clk_i);
  endtask

  task automatic acc(input int m, input logic [31:0] a, input bit w, input string tag);
    cyc(1'b1, m, a, w, 1'b0, 7'h0, 32'h0, tag);
  endtask

  task automatic wr(input logic [6:0] ca, input logic [31:0] wd, input string tag);
    cyc(1'b0, 0, 32'h0, 1'b0, 1'b1, ca, wd, tag);
  endtask

  task automatic rd(input logic [6:0] ca, input string tag);
    acc_valid_i = 1'b0; cfg_we_i = 1'b0; cfg_addr_i = ca;
    #1;
    check({tag, " readback"}, cfg_rdata_o, m_rd(ca));
    @(negedge clk_i);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) begin
      m_st[r] = '0; m_en[r] = '0; m_vld[r] = 1'b0; m_rt[r] = '0;
    end
    m_gen = 1'b0; m_ev = 1'b0; m_ew = 1'b0; m_em = 0; m_ea = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(7'h40, "R1");
    rd(7'h03, "R1");
    rd(7'h41, "R1");
    acc(0, 32'h0000_5000, 1'b0, "R1");

    // R2 disabled passes all
    acc(3, 32'hFFFF_FFE0, 1'b1, "R2");

    // R4 low bits of bounds dropped; R11 map
    wr(7'h00, 32'h0000_101F, "R11");
    wr(7'h01, 32'h0000_1FE7, "R11");
    wr(7'h02, 32'h1, "R11");
    wr(7'h03, 32'h0001_0003, "R11");
    wr(7'h04, 32'h0000_1800, "R11");
    wr(7'h05, 32'h0000_27E0, "R11");
    wr(7'h06, 32'h1, "R11");
    wr(7'h07, 32'h0006_0000, "R11");
    wr(7'h08, 32'h0000_8000, "R5");
    wr(7'h09, 32'h0000_8FE0, "R5");
    wr(7'h0B, 32'hFFFF_FFFF, "R5");
    rd(7'h00, "R4");
    rd(7'h01, "R4");
    rd(7'h0B, "R11");
    wr(7'h40, 32'h1, "R2");
    rd(7'h40, "R11");

    acc(0, 32'h0000_0FFF, 1'b0, "R4");
    rd(7'h41, "R8");
    rd(7'h42, "R8");
    acc(0, 32'h0000_1000, 1'b0, "R4");
    acc(0, 32'h0000_1FFF, 1'b1, "R4");
    acc(0, 32'h0000_2000, 1'b1, "R9");
    rd(7'h42, "R9");
    rd(7'h41, "R9");
    acc(1, 32'h0000_1900, 1'b1, "R7");
    acc(1, 32'h0000_1900, 1'b0, "R7");
    acc(1, 32'h0000_2100, 1'b0, "R3");
    acc(1, 32'h0000_27FF, 1'b1, "R4");
    acc(2, 32'h0000_1000, 1'b0, "R6");
    acc(2, 32'h0000_2000, 1'b1, "R6");
    acc(3, 32'h0000_1000, 1'b0, "R6");
    acc(0, 32'h0000_8000, 1'b0, "R5");
    acc(0, 32'h0000_8FFF, 1'b1, "R5");

    wr(7'h41, 32'h0, "R10");
    rd(7'h41, "R10");
    cyc(1'b1, 2, 32'h0000_1000, 1'b1, 1'b1, 7'h41, 32'h0, "R10");
    rd(7'h41, "R10");
    rd(7'h42, "R10");
    wr(7'h0A, 32'h1, "R5");
    acc(0, 32'h0000_8000, 1'b1, "R5");

    wr(7'h40, 32'h0, "R2");
    acc(3, 32'h0000_0000, 1'b1, "R2");
    wr(7'h41, 32'h0, "R2");
    acc(2, 32'h0000_0100, 1'b0, "R2");
    wr(7'h40, 32'h1, "R3");

    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) cyc(1'b1, $urandom_range(3), 32'($urandom_range(16'h9FFF)), 1'($urandom),
                           1'b1, 7'h41, 32'h0, "R10");
      else if (i % 53 == 0) rd(7'h42, "R9");
      else acc($urandom_range(3), 32'($urandom_range(16'h9FFF)), 1'($urandom), "R3");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule